// File: doc/BRIEF.md
# Time-Sliced RGB LED Brightness PWM Bank

This block drives a colour-mixed RGB LED display from a bank of 8-bit pulse-width generators. A display frame is cut into three colour slots, red, green and blue in turn. The block raises a one-hot slot select so that external drivers can enable the matching colour rows. Inside each slot every channel produces a pulse train whose duty sets the brightness of its LED. The number of channels is a parameter, from 24 up to 32.

Software or a controller writes a channel index and an 8-bit duty through a simple write port. Each write lands in a shadow register. The shadow values move into the active registers together at the next slot boundary, so a slot never shows a half-updated mix. The length of a slot is a whole number of 256-count PWM periods. Each count lasts a programmable number of clocks. This lets the slot be tuned to about 3 ms, so that a full three-slot frame stays under the 10 ms persistence-of-vision limit. The duty resolution is only as fine as brightness control needs.

Top module: `rgb_slot_pwm`

## Requirements
- R1: After reset, slot_sel is 3'b001 (red), every PWM output is low and every duty value (shadow and active) is zero.
- R2: A slot lasts exactly PERIODS*256*(presc+1) clocks. At each slot end slot_sel rotates 3'b001 -> 3'b010 -> 3'b100 -> 3'b001 (bit 0 red, bit 1 green, bit 2 blue).
- R3: slot_sel always has exactly one bit set.
- R4: The PWM count starts at 0 on the first clock of a slot and advances by one every presc+1 clocks, wrapping modulo 256. Output i is high while the count is below the active duty of channel i. So a duty of 0 never drives high, and a duty of 255 is high for 255 of 256 counts.
- R5: A write with wr_en high and wr_ch below N_CH stores wr_duty in the shadow register of that channel. The active duties, and so the outputs, change only at a slot end, when all shadow values are copied at once.
- R6: On the first clock of every slot, including the first after reset, all PWM outputs are low.
- R7: A write whose wr_ch is N_CH or higher changes no duty value.
- R8: A write in the same clock as a slot end goes to the shadow register and is applied at the following slot end, not the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Duty write strobe |
| wr_ch | input | CH_W | Channel index for the write |
| wr_duty | input | 8 | Duty value for the write |
| presc | input | PRESC_W | Clocks per PWM count, minus one |
| pwm_o | output | N_CH | Per-channel PWM outputs |
| slot_sel | output | 3 | One-hot colour slot select (bit 0 red, bit 1 green, bit 2 blue) |

## Verification
A wrong slot timer state shows at once as a slot_sel edge in the wrong clock, or as a shifted pulse edge on every channel with a nonzero duty. Because the count restarts at each boundary, a fault never lasts longer than one slot. A bad shadow or active duty shows no later than the first slot after the boundary that should have loaded it, as a pulse width that differs from the expected width. For that reason the bench compares every output on every clock against a model that counts elapsed clocks in the slot. It also totals the high clocks of each channel per slot.

// File: rtl/rgb_pwm_pkg.sv
package rgb_pwm_pkg;

  localparam int DUTY_W  = 8;
  localparam int COUNT_W = 8;

  typedef logic [2:0] slot_t;

  localparam slot_t SLOT_RED   = 3'b001;
  localparam slot_t SLOT_GREEN = 3'b010;
  localparam slot_t SLOT_BLUE  = 3'b100;

  // Next colour in the fixed red, green, blue order.
  function automatic slot_t next_slot(input slot_t cur);
    slot_t nxt;
    case (cur)
      SLOT_RED:   nxt = SLOT_GREEN;
      SLOT_GREEN: nxt = SLOT_BLUE;
      default:    nxt = SLOT_RED;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pwm_slot_timer.sv
module pwm_slot_timer
  import rgb_pwm_pkg::*;
#(
  parameter int PRESC_W = 16,
  parameter int PERIODS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  output logic [COUNT_W-1:0] count,
  output slot_t              slot_sel,
  output logic               slot_end,
  output logic               blank
);

  localparam int PER_W = (PERIODS > 1) ? $clog2(PERIODS) : 1;
  localparam logic [PER_W-1:0]   LAST_PER   = PER_W'(PERIODS - 1);
  localparam logic [COUNT_W-1:0] LAST_COUNT = '1;

  logic [PRESC_W-1:0] pre_q, pre_d;
  logic [COUNT_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0]   per_q, per_d;
  slot_t              sel_q, sel_d;
  logic               blank_q, blank_d;

  logic tick;
  logic wrap;

  // next-state
  always_comb begin
    tick     = (pre_q >= presc);
    wrap     = tick && (cnt_q == LAST_COUNT);
    slot_end = wrap && (per_q == LAST_PER);

    pre_d   = tick ? '0 : pre_q + 1'b1;
    cnt_d   = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
    per_d   = per_q;
    if (slot_end)  per_d = '0;
    else if (wrap) per_d = per_q + 1'b1;
    sel_d   = slot_end ? next_slot(sel_q) : sel_q;
    blank_d = slot_end;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      per_q   <= '0;
      sel_q   <= SLOT_RED;
      blank_q <= 1'b1;
    end else begin
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      sel_q   <= sel_d;
      blank_q <= blank_d;
    end
  end

  assign count    = cnt_q;
  assign slot_sel = sel_q;
  assign blank    = blank_q;

  // R3
  slot_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_q) == 1);

  // R2
  slot_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> sel_q == next_slot($past(sel_q)));

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(sel_q));

  // R4
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> cnt_q == '0);

endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank
  import rgb_pwm_pkg::*;
#(
  parameter int N_CH = 24,
  parameter int CH_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CH_W-1:0]              wr_ch,
  input  logic [DUTY_W-1:0]            wr_duty,
  input  logic                         load,
  output logic [N_CH-1:0][DUTY_W-1:0]  active
);

  logic [N_CH-1:0][DUTY_W-1:0] shadow_q, shadow_d;
  logic [N_CH-1:0][DUTY_W-1:0] active_q, active_d;
  logic                        wr_ok;

  assign wr_ok = wr_en && (int'(wr_ch) < N_CH);

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic sel_wr;
      assign sel_wr = wr_ok && (int'(wr_ch) == g);

      // next-state: shadow takes writes, active takes the old shadow on load
      always_comb begin
        shadow_d[g] = sel_wr ? wr_duty : shadow_q[g];
        active_d[g] = load ? shadow_q[g] : active_q[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_q[g] <= '0;
          active_q[g] <= '0;
        end else begin
          shadow_q[g] <= shadow_d[g];
          active_q[g] <= active_d[g];
        end
      end
    end
  endgenerate

  assign active = active_q;

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));

  // R7
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_ch) >= N_CH) |=> $stable(shadow_q));

  // R8
  load_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active_q == $past(shadow_q));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import rgb_pwm_pkg::*;
#(
  parameter int N_CH = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [COUNT_W-1:0]           count,
  input  logic                         blank,
  input  logic [N_CH-1:0][DUTY_W-1:0]  active,
  output logic [N_CH-1:0]              pwm
);

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_cmp
      always_comb begin
        pwm[g] = !blank && (count < active[g]);
      end

      // R4
      duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active[g] == '0) |-> !pwm[g]);

      // R4
      duty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank && active[g] == '1 && count != '1) |-> pwm[g]);
    end
  endgenerate

endmodule

// File: rtl/rgb_slot_pwm.sv
module rgb_slot_pwm
  import rgb_pwm_pkg::*;
#(
  parameter int N_CH    = 24,
  parameter int PRESC_W = 16,
  parameter int PERIODS = 4,
  parameter int CH_W    = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [7:0]         wr_duty,
  input  logic [PRESC_W-1:0] presc,
  output logic [N_CH-1:0]    pwm_o,
  output logic [2:0]         slot_sel
);

  logic [COUNT_W-1:0]          count;
  logic                        slot_end;
  logic                        blank;
  slot_t                       sel;
  logic [N_CH-1:0][DUTY_W-1:0] active;

  pwm_slot_timer #(
    .PRESC_W (PRESC_W),
    .PERIODS (PERIODS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .presc    (presc),
    .count    (count),
    .slot_sel (sel),
    .slot_end (slot_end),
    .blank    (blank)
  );

  pwm_duty_bank #(
    .N_CH (N_CH),
    .CH_W (CH_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_duty (wr_duty),
    .load    (slot_end),
    .active  (active)
  );

  pwm_compare #(
    .N_CH (N_CH)
  ) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .count  (count),
    .blank  (blank),
    .active (active),
    .pwm    (pwm_o)
  );

  assign slot_sel = sel;

  // R6
  slot_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> pwm_o == '0);

endmodule

// File: tb/rgb_slot_pwm_bench.sv
module rgb_slot_pwm_bench;

  localparam int N_CH    = 24;
  localparam int PRESC_W = 8;
  localparam int PERIODS = 2;
  localparam int CH_W    = $clog2(N_CH);

  logic               clk;
  logic               rst_n;
  logic               wr_en;
  logic [CH_W-1:0]    wr_ch;
  logic [7:0]         wr_duty;
  logic [PRESC_W-1:0] presc;
  logic [N_CH-1:0]    pwm_o;
  logic [2:0]         slot_sel;

  rgb_slot_pwm #(
    .N_CH (N_CH), .PRESC_W (PRESC_W), .PERIODS (PERIODS)
  ) u_rgb_slot_pwm (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_ch (wr_ch),
    .wr_duty (wr_duty), .presc (presc), .pwm_o (pwm_o), .slot_sel (slot_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string phase  = "R4";

  // behavioural reference model
  int t;
  int slot_idx;
  int shadow [N_CH];
  int active [N_CH];
  int hc     [N_CH];
  int pval;
  int slot_len;

  assign pval     = int'(presc) + 1;
  assign slot_len = PERIODS * 256 * pval;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t = 0;
      slot_idx = 0;
      for (int i = 0; i < N_CH; i++) begin
        shadow[i] = 0;
        active[i] = 0;
      end
    end else begin
      if (t == slot_len - 1) begin
        for (int i = 0; i < N_CH; i++) active[i] = shadow[i];
        t = 0;
        slot_idx = (slot_idx + 1) % 3;
      end else begin
        t = t + 1;
      end
      if (wr_en && int'(wr_ch) < N_CH) shadow[int'(wr_ch)] = int'(wr_duty);
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  // every-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) hc[i] = 0;
    end else begin
      logic [2:0] exp_sel;
      exp_sel = 3'b001 << slot_idx;
      check("R2", slot_sel == exp_sel, int'(slot_sel), int'(exp_sel));
      check("R3", $countones(slot_sel) == 1, $countones(slot_sel), 1);
      for (int i = 0; i < N_CH; i++) begin
        bit e;
        e = (t != 0) && (((t / pval) % 256) < active[i]);
        if (pwm_o[i] !== e) begin
          checks++;
          errors++;
          $display("FAIL %s: ch%0d actual=%0d expected=%0d (t=%0d)",
                   (t == 0) ? "R6" : phase, i, pwm_o[i], e, t);
        end
        hc[i] = hc[i] + int'(pwm_o[i]);
      end
      if (t == 0) check("R6", pwm_o == '0, int'(pwm_o != '0), 0);
      if (t == slot_len - 1) begin
        for (int i = 0; i < N_CH; i++) begin
          int exp_hc;
          exp_hc = PERIODS * active[i] * pval - ((active[i] > 0) ? 1 : 0);
          check(phase, hc[i] == exp_hc, hc[i], exp_hc);
          hc[i] = 0;
        end
      end
    end
  end

  task automatic write_duty(input int ch, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_ch   = CH_W'(ch);
    wr_duty = 8'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_slots(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (t != 0) @(negedge clk);
    end
  endtask

  task automatic do_reset(input int p);
    @(negedge clk);
    rst_n = 1'b0;
    presc = PRESC_W'(p);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_ch   = '0;
    wr_duty = '0;
    presc   = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", slot_sel == 3'b001, int'(slot_sel), 1);
    check("R1", pwm_o == '0, int'(pwm_o != '0), 0);
    rst_n = 1'b1;

    // R4: extremes and mid values, effective from next slot
    phase = "R4";
    write_duty(0, 0);
    write_duty(1, 255);
    write_duty(2, 1);
    write_duty(3, 128);
    for (int i = 4; i < N_CH; i++) write_duty(i, i * 10);
    wait_slots(2);

    // R5: mid-slot write must not touch the current slot
    phase = "R5";
    repeat (100) @(negedge clk);
    write_duty(3, 17);
    write_duty(1, 3);
    wait_slots(2);

    // R8: write in the very clock of a slot end
    phase = "R8";
    while (t != slot_len - 2) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = CH_W'(4); wr_duty = 8'd200;
    @(negedge clk);
    wr_en = 1'b0;
    wait_slots(2);

    // R7: out-of-range channel indices are ignored
    phase = "R7";
    write_duty(30, 99);
    write_duty(31, 250);
    write_duty(N_CH, 77);
    wait_slots(2);

    // R2/R4 with a longer count step
    phase = "R4";
    do_reset(2);
    check("R1", slot_sel == 3'b001, int'(slot_sel), 1);
    write_duty(5, 255);
    write_duty(6, 64);
    write_duty(7, 2);
    wait_slots(4);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule